// File: doc/BRIEF.md
# Clean Writeback Filter Table

This block sits beside the writeback queue of a private second-level cache and decides, for each line being evicted, whether the line travels to the shared third-level victim cache or is dropped. Modified victims always go out. Unmodified victims are checked against a small history of line addresses that were recently sent down. If the address is remembered, the copy below is presumed to still exist and the transfer is squashed. If it is not remembered, the line is sent and its address is recorded. The history holds only hints: a remembered line that has since left the victim cache costs a later refetch, never a wrong result.

The history is a set-associative tag store, 512 entries by default in four ways, with true least-recently-used replacement kept as a per-way age. The requester raises a request with the line address and two qualifiers (modified, remove-hint). The block accepts it in a cycle where ready is high and answers in the following cycle with a single squash flag. A remove-hint request lets an external eviction notice from the victim cache delete a stale address.

Top module: `clean_wb_filter`

## Requirements
- R1: After reset the history is empty and no request is pending: rsp_valid is 0, req_ready is 1, and the first unmodified request for any address gets rsp_squash = 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1; in the next cycle rsp_valid is 1 and req_ready is 0, and in the cycle after that req_ready is 1 again with rsp_valid 0.
- R3: A modified request (req_dirty = 1, req_inval = 0) always gets rsp_squash = 0, allocates nothing and does not change the recency order of the set.
- R4: An unmodified request (req_dirty = 0, req_inval = 0) whose address is held in the history gets rsp_squash = 1.
- R5: An unmodified request whose address is not held gets rsp_squash = 0 and records the address, so an identical request right after it gets rsp_squash = 1.
- R6: The set is chosen by the low log2(ENTRIES/WAYS) bits of req_addr (7 bits by default) and the remaining upper bits are the tag; up to WAYS distinct tags in one set are held at once.
- R7: When an unmodified miss finds every way of its set occupied, the least recently used way is replaced; both an unmodified hit and an allocation make that way the most recently used.
- R8: A remove-hint request (req_inval = 1, req_dirty ignored) gets rsp_squash = 0 and deletes a matching entry, so the next unmodified request to that address gets rsp_squash = 0; for an absent address it changes nothing.
- R9: Sets are independent: activity in one set does not evict or alter entries of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | LINE_ADDR_W | Line address of the victim |
| req_dirty | input | 1 | Victim is modified |
| req_inval | input | 1 | Remove-hint request instead of a victim |
| rsp_valid | output | 1 | Response for the request taken last cycle |
| rsp_squash | output | 1 | 1: drop the writeback; 0: send it |

## Verification
The assertions assume that a requester whose request is not yet taken keeps req_valid high and holds the address and qualifiers unchanged until ready, and that the history never gets two valid copies of one tag in a set, which follows from allocating only on a miss. The bench drives every request on the falling edge, waits for ready before letting the rising edge take it, and drops valid right after the handshake, so the hold rule is never broken. Address sequences are chosen per set so that the expected recency order, and hence which tag is evicted, can be worked out by hand for each step.

// File: rtl/wbf_pkg.sv
// Shared types of the clean writeback filter.
// Assumes: nothing beyond IEEE 1800-2017.
package wbf_pkg;
    // Kind of request held in the lookup stage.
    typedef enum logic [1:0] {
        WBF_OP_CLEAN = 2'd0,
        WBF_OP_DIRTY = 2'd1,
        WBF_OP_INVAL = 2'd2
    } wbf_op_e;
endpackage

// File: rtl/wbf_way_match.sv
// Compares a lookup tag against every way of one set and reports the
// matching way. Assumes at most one valid way holds a given tag.
module wbf_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 25,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tags[w] == look_tag);
    end

    // Encode the matching way.
    always_comb begin
        any_hit = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/wbf_lru_age.sv
// True LRU for one set kept as per-way ages (0 = most recent,
// WAYS-1 = least recent). Picks a victim (lowest empty way, else the
// oldest) and computes the ages after touching a way.
// Assumes the incoming ages form a permutation of 0..WAYS-1.
module wbf_lru_age #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [WAY_W-1:0]           victim_way,
    output logic [WAYS-1:0][WAY_W-1:0] ages_next
);
    logic [WAY_W-1:0] touch_age;
    assign touch_age = ages[touch_way];

    // Age update: touched way becomes newest, younger ways grow older.
    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (touch_way == WAY_W'(w))
                ages_next[w] = '0;
            else if (ages[w] < touch_age)
                ages_next[w] = ages[w] + 1'b1;
            else
                ages_next[w] = ages[w];
        end
    end

    // Victim choice: first empty way, otherwise the oldest way.
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!way_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (ages[w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/clean_wb_filter.sv
// Clean writeback filter: a set-associative history of line addresses
// already sent to the victim cache. Unmodified victims that hit are
// squashed, misses are sent and recorded, modified victims always pass,
// remove-hint requests delete an entry. One request in flight: taken
// when ready, answered the next cycle, table updated at the end of that
// cycle. Assumes ENTRIES/WAYS is a power of two of at least 2 and the
// requester holds its request until ready.
module clean_wb_filter #(
    parameter int LINE_ADDR_W = 32,
    parameter int ENTRIES     = 512,
    parameter int WAYS        = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [LINE_ADDR_W-1:0] req_addr,
    input  logic                   req_dirty,
    input  logic                   req_inval,
    output logic                   rsp_valid,
    output logic                   rsp_squash
);
    import wbf_pkg::*;

    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LINE_ADDR_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    // Table storage.
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] age_q   [SETS];

    // Lookup stage.
    logic                   s1_valid;
    logic [LINE_ADDR_W-1:0] s1_addr;
    wbf_op_e                s1_op;
    logic                   accept;
    wbf_op_e                req_op;

    logic [IDX_W-1:0]           s1_idx;
    logic [TAG_W-1:0]           s1_tag;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0][WAY_W-1:0] set_ages;
    logic [WAYS-1:0]            hit_vec;
    logic                       any_hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           victim_way;
    logic [WAY_W-1:0]           touch_way;
    logic [WAYS-1:0][WAY_W-1:0] ages_next;

    assign req_ready = !s1_valid;
    assign accept    = req_valid && req_ready;
    assign req_op    = req_inval ? WBF_OP_INVAL :
                       (req_dirty ? WBF_OP_DIRTY : WBF_OP_CLEAN);

    assign s1_idx    = s1_addr[IDX_W-1:0];
    assign s1_tag    = s1_addr[LINE_ADDR_W-1:IDX_W];
    assign set_tags  = tag_q[s1_idx];
    assign set_valid = valid_q[s1_idx];
    assign set_ages  = age_q[s1_idx];
    assign touch_way = any_hit ? hit_way : victim_way;

    wbf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tags  (set_tags),
        .way_valid (set_valid),
        .look_tag  (s1_tag),
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .hit_way   (hit_way)
    );

    wbf_lru_age #(.WAYS(WAYS)) u_lru (
        .ages       (set_ages),
        .way_valid  (set_valid),
        .touch_way  (touch_way),
        .victim_way (victim_way),
        .ages_next  (ages_next)
    );

    // Capture an accepted request for its lookup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_addr  <= '0;
            s1_op    <= WBF_OP_CLEAN;
        end else if (accept) begin
            s1_valid <= 1'b1;
            s1_addr  <= req_addr;
            s1_op    <= req_op;
        end else begin
            s1_valid <= 1'b0;
        end
    end

    // Update valid bits and recency at the end of the lookup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (s1_valid) begin
            case (s1_op)
                WBF_OP_CLEAN: begin
                    age_q[s1_idx] <= ages_next;
                    if (!any_hit) valid_q[s1_idx][victim_way] <= 1'b1;
                end
                WBF_OP_INVAL: begin
                    if (any_hit) valid_q[s1_idx][hit_way] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Write the tag of a newly recorded line.
    always_ff @(posedge clk) begin
        if (s1_valid && (s1_op == WBF_OP_CLEAN) && !any_hit)
            tag_q[s1_idx][victim_way] <= s1_tag;
    end

    // Response in the lookup cycle.
    assign rsp_valid  = s1_valid;
    assign rsp_squash = s1_valid && (s1_op == WBF_OP_CLEAN) && any_hit;

    // Ages of a set must stay a permutation of 0..WAYS-1.
    function automatic logic ages_are_perm(input logic [WAYS-1:0][WAY_W-1:0] a);
        logic [WAYS-1:0] seen;
        seen = '0;
        for (int w = 0; w < WAYS; w++) seen[a[w]] = 1'b1;
        return &seen;
    endfunction

    // R2: an accepted request is answered in the next cycle, ready low.
    a_r2_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    // R2: one response per request, never two in a row.
    a_r2_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: requester keeps a refused request stable (input rule).
    a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
            && $stable(req_dirty) && $stable(req_inval)));

    // R3: a modified victim is never squashed.
    a_r3_dirty_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_dirty && !req_inval) |=> !rsp_squash);

    // R8: a remove-hint request is never squashed.
    a_r8_inval_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_inval) |=> !rsp_squash);

    // R6: a tag is held in at most one way of a set.
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $onehot0(hit_vec));

    // R7: recency of the looked-up set is a strict order.
    a_r7_age_perm: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> ages_are_perm(set_ages));
endmodule

// File: tb/clean_wb_filter_tb_top.sv
// Directed bench for the clean writeback filter.
module clean_wb_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_dirty = 1'b0;
    logic        req_inval = 1'b0;
    logic        rsp_valid;
    logic        rsp_squash;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    clean_wb_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_dirty(req_dirty), .req_inval(req_inval),
        .rsp_valid(rsp_valid), .rsp_squash(rsp_squash)
    );

    always #10 clk = ~clk;

    // Address from tag and 7-bit set index (default geometry).
    function automatic logic [31:0] mk(input int tag, input int idx);
        return {tag[24:0], idx[6:0]};
    endfunction

    task automatic chk(input string rq, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", rq, act, exp);
        end
    endtask

    // Issue one request and check its response.
    task automatic issue(input logic [31:0] a, input logic d, input logic inv,
                         input logic exp_sq, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_dirty = d; req_inval = inv;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({rq, " rsp_valid"}, rsp_valid, 1'b1);
        chk({rq, " squash"}, rsp_squash, exp_sq);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rsp_valid idle", rsp_valid, 1'b0);
        chk("R1 ready idle", req_ready, 1'b1);
        issue(mk(77, 3), 1'b0, 1'b0, 1'b0, "R1 first clean");
    endtask

    task automatic t_handshake();
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk(5, 40); req_dirty = 1'b0; req_inval = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp after accept", rsp_valid, 1'b1);
        chk("R2 ready low in rsp", req_ready, 1'b0);
        @(negedge clk);
        chk("R2 ready back", req_ready, 1'b1);
        chk("R2 rsp single", rsp_valid, 1'b0);
    endtask

    task automatic t_miss_alloc();
        issue(mk(9, 50), 1'b0, 1'b0, 1'b0, "R5 miss sends");
        issue(mk(9, 50), 1'b0, 1'b0, 1'b1, "R4 hit squashes");
        issue(mk(9, 50), 1'b0, 1'b0, 1'b1, "R4 hit again");
    endtask

    task automatic t_dirty();
        issue(mk(3, 30), 1'b1, 1'b0, 1'b0, "R3 dirty new");
        issue(mk(3, 30), 1'b0, 1'b0, 1'b0, "R3 dirty no alloc");
        issue(mk(3, 30), 1'b1, 1'b0, 1'b0, "R3 dirty present");
        issue(mk(3, 30), 1'b0, 1'b0, 1'b1, "R3 entry kept");
        for (int t = 1; t <= 4; t++) issue(mk(t, 20), 1'b0, 1'b0, 1'b0, "R3 fill");
        issue(mk(1, 20), 1'b1, 1'b0, 1'b0, "R3 dirty on lru");
        issue(mk(5, 20), 1'b0, 1'b0, 1'b0, "R3 new evicts");
        issue(mk(2, 20), 1'b0, 1'b0, 1'b1, "R3 other kept");
        issue(mk(1, 20), 1'b0, 1'b0, 1'b0, "R3 no refresh by dirty");
    endtask

    task automatic t_lru();
        for (int t = 1; t <= 4; t++) issue(mk(t, 5), 1'b0, 1'b0, 1'b0, "R6 fill four tags");
        for (int t = 1; t <= 4; t++) issue(mk(t, 5), 1'b0, 1'b0, 1'b1, "R6 four held");
        // order now 4,3,2,1 newest first
        issue(mk(1, 5), 1'b0, 1'b0, 1'b1, "R7 refresh 1");
        issue(mk(9, 5), 1'b0, 1'b0, 1'b0, "R7 fifth evicts 2");
        issue(mk(1, 5), 1'b0, 1'b0, 1'b1, "R7 refreshed kept");
        issue(mk(2, 5), 1'b0, 1'b0, 1'b0, "R7 lru gone");
        issue(mk(4, 5), 1'b0, 1'b0, 1'b1, "R7 4 kept");
        issue(mk(9, 5), 1'b0, 1'b0, 1'b1, "R7 9 kept");
        issue(mk(3, 5), 1'b0, 1'b0, 1'b0, "R7 3 evicted by 2");
    endtask

    task automatic t_inval();
        issue(mk(11, 60), 1'b0, 1'b0, 1'b0, "R8 alloc");
        issue(mk(12, 60), 1'b0, 1'b0, 1'b0, "R8 alloc other");
        issue(mk(11, 60), 1'b1, 1'b1, 1'b0, "R8 remove");
        issue(mk(11, 60), 1'b0, 1'b0, 1'b0, "R8 removed misses");
        issue(mk(11, 60), 1'b0, 1'b0, 1'b1, "R8 realloc");
        issue(mk(99, 60), 1'b0, 1'b1, 1'b0, "R8 remove absent");
        issue(mk(12, 60), 1'b0, 1'b0, 1'b1, "R8 absent no effect");
    endtask

    task automatic t_sets();
        issue(mk(7, 10), 1'b0, 1'b0, 1'b0, "R9 alloc set 10");
        for (int t = 20; t < 26; t++) issue(mk(t, 9), 1'b0, 1'b0, 1'b0, "R9 churn set 9");
        issue(mk(7, 10), 1'b0, 1'b0, 1'b1, "R9 set 10 intact");
        issue(mk(7, 9), 1'b0, 1'b0, 1'b0, "R9 same tag other set");
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", rsp_valid, 1'b0);
        rst_n = 1'b1;
        t_reset();
        t_handshake();
        t_miss_alloc();
        t_dirty();
        t_lru();
        t_inval();
        t_sets();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule